// File: doc/BRIEF.md
# Adaptive Page Close Decision Unit

This block decides, for each column access that a memory controller is about to issue, whether the access should also close its bank through an auto-precharge. The controller presents the request's rank, bank and row, together with the page policy in force, how many column accesses the open row has served so far, a per-row access cap, and a snapshot of its pending request entries. One cycle later the unit returns a single close decision.

Under the two fixed policies, the row is always kept open or always closed. Under the two adaptive policies, the unit looks ahead through the pending entries. A pending request that wants the same row argues for keeping the row open. A pending request that wants a different row in the same bank argues for closing it. The access cap overrides every policy, so that one row cannot hold a bank indefinitely.

Top module: `page_close_unit`

## Requirements
- R1: `dec_valid` is high in the cycle after each cycle in which `req_valid` is high, and low after every cycle in which `req_valid` is low. Both outputs are 0 after reset.
- R2: `dec_close` changes only on the edge that raises `dec_valid`. It keeps its value while no request is strobed.
- R3: `policy` is encoded as 0 = open, 1 = open-adaptive, 2 = close, 3 = close-adaptive. Under the open policy (0), `dec_close` is 0 unless R5 applies.
- R4: Under the close policy (2), `dec_close` is 1 for every request.
- R5: When `max_acc` is nonzero and `row_acc_cnt` >= `max_acc`, `dec_close` is 1 under every policy. A `max_acc` of 0 means that no cap applies.
- R6: A valid pending entry i whose rank, bank and row all equal the request's counts as a hit. A valid entry with the same rank and bank but a different row counts as a conflict. Entries with a different rank or a different bank have no effect, and invalid entries have no effect.
- R7: Under open-adaptive (1), `dec_close` is 1 exactly when there is no hit and at least one conflict.
- R8: Under close-adaptive (3), `dec_close` is 1 exactly when there is no hit.
- R9: When `self_valid` is high, the pending entry at index `self_idx` is the request itself and is left out of the hit and conflict scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_rank | input | RANK_W | Rank of the request |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| self_valid | input | 1 | The request also sits in the pending snapshot |
| self_idx | input | IDX_W | Snapshot index of the request itself |
| policy | input | 2 | Page policy (R3 encoding) |
| row_acc_cnt | input | CNT_W | Accesses to the open row, including this one |
| max_acc | input | CNT_W | Per-row access cap, 0 = unlimited |
| pend_valid | input | NUM_ENTRIES | Pending entry valid bits |
| pend_rank | input | NUM_ENTRIES*RANK_W | Packed pending ranks, entry i at bits i*RANK_W |
| pend_bank | input | NUM_ENTRIES*BANK_W | Packed pending banks |
| pend_row | input | NUM_ENTRIES*ROW_W | Packed pending rows |
| dec_valid | output | 1 | Decision valid |
| dec_close | output | 1 | Auto-precharge decision |

## Verification
The bench builds the unit with four pending entries, a one-bit rank, a two-bit bank, a four-bit row and a four-bit counter. With these widths, the bench can set every entry by hand, place hits, conflicts, rank-only and bank-only mismatches side by side, and mark any slot as the request itself. The four-bit counter lets the bench reach the cap exactly at, above and below its limit, and with a cap of zero at the counter's maximum value.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [1:0] {
      POL_OPEN        = 2'd0,
      POL_OPEN_ADAPT  = 2'd1,
      POL_CLOSE       = 2'd2,
      POL_CLOSE_ADAPT = 2'd3
   } page_pol_e;
endpackage

// File: rtl/pcu_entry_cmp.sv
module pcu_entry_cmp #(
   parameter int RANK_W = 2,
   parameter int BANK_W = 3,
   parameter int ROW_W  = 14,
   parameter int IDX_W  = 3,
   parameter int SLOT   = 0
) (
   input  logic              ent_valid,
   input  logic [RANK_W-1:0] ent_rank,
   input  logic [BANK_W-1:0] ent_bank,
   input  logic [ROW_W-1:0]  ent_row,
   input  logic [RANK_W-1:0] req_rank,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic              self_valid,
   input  logic [IDX_W-1:0]  self_idx,
   output logic              hit,
   output logic              conflict
);
   logic is_self;
   logic same_rb;

   assign is_self  = self_valid && (self_idx == IDX_W'(SLOT));
   assign same_rb  = ent_valid && !is_self && (ent_rank == req_rank) && (ent_bank == req_bank);
   assign hit      = same_rb && (ent_row == req_row);
   assign conflict = same_rb && (ent_row != req_row);
endmodule

// File: rtl/pcu_limit_chk.sv
module pcu_limit_chk #(
   parameter int CNT_W = 8
) (
   input  logic [CNT_W-1:0] row_acc_cnt,
   input  logic [CNT_W-1:0] max_acc,
   output logic             limit_hit
);
   assign limit_hit = (max_acc != '0) && (row_acc_cnt >= max_acc);
endmodule

// File: rtl/pcu_decide.sv
module pcu_decide
   import pcu_pkg::*;
(
   input  logic [1:0] policy,
   input  logic       limit_hit,
   input  logic       any_hit,
   input  logic       any_conf,
   output logic       close_d
);
   page_pol_e pol;
   assign pol = page_pol_e'(policy);

   always_comb begin
      close_d = 1'b0;
      if (limit_hit) begin
         close_d = 1'b1;
      end else begin
         unique case (pol)
            POL_OPEN:        close_d = 1'b0;
            POL_CLOSE:       close_d = 1'b1;
            POL_OPEN_ADAPT:  close_d = !any_hit && any_conf;
            POL_CLOSE_ADAPT: close_d = !any_hit;
            default:         close_d = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/page_close_unit.sv
module page_close_unit #(
   parameter int NUM_ENTRIES = 8,
   parameter int RANK_W      = 2,
   parameter int BANK_W      = 3,
   parameter int ROW_W       = 14,
   parameter int CNT_W       = 8,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [RANK_W-1:0]             req_rank,
   input  logic [BANK_W-1:0]             req_bank,
   input  logic [ROW_W-1:0]              req_row,
   input  logic                          self_valid,
   input  logic [IDX_W-1:0]              self_idx,
   input  logic [1:0]                    policy,
   input  logic [CNT_W-1:0]              row_acc_cnt,
   input  logic [CNT_W-1:0]              max_acc,
   input  logic [NUM_ENTRIES-1:0]        pend_valid,
   input  logic [NUM_ENTRIES*RANK_W-1:0] pend_rank,
   input  logic [NUM_ENTRIES*BANK_W-1:0] pend_bank,
   input  logic [NUM_ENTRIES*ROW_W-1:0]  pend_row,
   output logic                          dec_valid,
   output logic                          dec_close
);
   if (NUM_ENTRIES < 1) begin : g_bad_entries
      $error("page_close_unit: NUM_ENTRIES must be at least 1");
   end
   if (RANK_W < 1 || BANK_W < 1 || ROW_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("page_close_unit: all field widths must be at least 1");
   end

   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [NUM_ENTRIES-1:0] conf_vec;
   logic                   limit_hit;
   logic                   close_d;

   for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
      pcu_entry_cmp #(
         .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
         .IDX_W(IDX_W), .SLOT(i)
      ) u_cmp (
         .ent_valid (pend_valid[i]),
         .ent_rank  (pend_rank[i*RANK_W +: RANK_W]),
         .ent_bank  (pend_bank[i*BANK_W +: BANK_W]),
         .ent_row   (pend_row[i*ROW_W +: ROW_W]),
         .req_rank  (req_rank),
         .req_bank  (req_bank),
         .req_row   (req_row),
         .self_valid(self_valid),
         .self_idx  (self_idx),
         .hit       (hit_vec[i]),
         .conflict  (conf_vec[i])
      );
   end

   pcu_limit_chk #(.CNT_W(CNT_W)) u_limit (
      .row_acc_cnt(row_acc_cnt),
      .max_acc    (max_acc),
      .limit_hit  (limit_hit)
   );

   pcu_decide u_decide (
      .policy   (policy),
      .limit_hit(limit_hit),
      .any_hit  (|hit_vec),
      .any_conf (|conf_vec),
      .close_d  (close_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_close <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) dec_close <= close_d;
      end
   end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [1:0]       policy,
   input logic [CNT_W-1:0] row_acc_cnt,
   input logic [CNT_W-1:0] max_acc,
   input logic             dec_valid,
   input logic             dec_close
);
   // R1
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   // R1
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !dec_valid);
   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(dec_close));
   // R4
   close_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && policy == 2'd2) |=> dec_close);
   // R5
   limit_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && max_acc != '0 && row_acc_cnt >= max_acc) |=> dec_close);
   // R3
   open_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && policy == 2'd0 && (max_acc == '0 || row_acc_cnt < max_acc)) |=> !dec_close);
endmodule

bind page_close_unit pcu_checker #(.CNT_W(CNT_W)) u_pcu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .policy     (policy),
   .row_acc_cnt(row_acc_cnt),
   .max_acc    (max_acc),
   .dec_valid  (dec_valid),
   .dec_close  (dec_close)
);

// File: tb/tb_page_close_unit.sv
module tb_page_close_unit;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int RW = 1;
   localparam int BW = 2;
   localparam int WW = 4;
   localparam int CW = 4;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [RW-1:0] req_rank = '0;
   logic [BW-1:0] req_bank = '0;
   logic [WW-1:0] req_row = '0;
   logic          self_valid = 1'b0;
   logic [IW-1:0] self_idx = '0;
   logic [1:0]    policy = '0;
   logic [CW-1:0] row_acc_cnt = '0;
   logic [CW-1:0] max_acc = '0;
   logic [N-1:0]    pend_valid = '0;
   logic [N*RW-1:0] pend_rank = '0;
   logic [N*BW-1:0] pend_bank = '0;
   logic [N*WW-1:0] pend_row = '0;
   logic dec_valid, dec_close;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   page_close_unit #(.NUM_ENTRIES(N), .RANK_W(RW), .BANK_W(BW), .ROW_W(WW), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rank(req_rank),
      .req_bank(req_bank), .req_row(req_row), .self_valid(self_valid), .self_idx(self_idx),
      .policy(policy), .row_acc_cnt(row_acc_cnt), .max_acc(max_acc),
      .pend_valid(pend_valid), .pend_rank(pend_rank), .pend_bank(pend_bank),
      .pend_row(pend_row), .dec_valid(dec_valid), .dec_close(dec_close));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic clear_entries();
      pend_valid = '0; pend_rank = '0; pend_bank = '0; pend_row = '0;
      self_valid = 1'b0; self_idx = '0;
   endtask

   task automatic set_entry(input int i, input logic [RW-1:0] rk,
                            input logic [BW-1:0] bk, input logic [WW-1:0] rw);
      pend_valid[i] = 1'b1;
      pend_rank[i*RW +: RW] = rk;
      pend_bank[i*BW +: BW] = bk;
      pend_row[i*WW +: WW] = rw;
   endtask

   // Drive at the falling edge; the result is registered on the next rising
   // edge and sampled at the falling edge after it.
   task automatic strobe(input string req, input logic [1:0] pol, input logic exp);
      policy = pol;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, dec_valid, 1'b1);
      check(req, dec_close, exp);
   endtask

   task automatic t_reset();
      check("R1 reset valid", dec_valid, 1'b0);
      check("R2 reset close", dec_close, 1'b0);
   endtask

   task automatic t_fixed();
      clear_entries();
      req_rank = 1'b0; req_bank = 2'd1; req_row = 4'd5;
      row_acc_cnt = 4'd3; max_acc = 4'd0;
      set_entry(0, 1'b0, 2'd1, 4'd9);
      strobe("R3 open with conflict", 2'd0, 1'b0);
      strobe("R4 close", 2'd2, 1'b1);
      set_entry(1, 1'b0, 2'd1, 4'd5);
      strobe("R4 close with hit", 2'd2, 1'b1);
      strobe("R3 open with hit", 2'd0, 1'b0);
   endtask

   task automatic t_limit();
      clear_entries();
      req_rank = 1'b1; req_bank = 2'd2; req_row = 4'd3;
      set_entry(0, 1'b1, 2'd2, 4'd3);
      max_acc = 4'd4; row_acc_cnt = 4'd4;
      strobe("R5 cap reached open", 2'd0, 1'b1);
      strobe("R5 cap reached open-adaptive hit", 2'd1, 1'b1);
      row_acc_cnt = 4'd7;
      strobe("R5 cap exceeded close-adaptive hit", 2'd3, 1'b1);
      row_acc_cnt = 4'd3;
      strobe("R5 below cap open", 2'd0, 1'b0);
      max_acc = 4'd0; row_acc_cnt = 4'd15;
      strobe("R5 zero cap unlimited", 2'd0, 1'b0);
   endtask

   task automatic t_open_adapt();
      clear_entries();
      req_rank = 1'b0; req_bank = 2'd3; req_row = 4'd10;
      max_acc = 4'd0; row_acc_cnt = 4'd1;
      strobe("R7 no entries", 2'd1, 1'b0);
      set_entry(2, 1'b0, 2'd3, 4'd11);
      strobe("R7 conflict only", 2'd1, 1'b0 | 1'b1);
      set_entry(3, 1'b0, 2'd3, 4'd10);
      strobe("R7 hit and conflict", 2'd1, 1'b0);
      clear_entries();
      set_entry(0, 1'b1, 2'd3, 4'd11);
      set_entry(1, 1'b0, 2'd2, 4'd11);
      strobe("R6 other rank and bank ignored", 2'd1, 1'b0);
      set_entry(2, 1'b0, 2'd3, 4'd4);
      pend_valid[2] = 1'b0;
      strobe("R6 invalid conflict ignored", 2'd1, 1'b0);
   endtask

   task automatic t_close_adapt();
      clear_entries();
      req_rank = 1'b1; req_bank = 2'd0; req_row = 4'd6;
      max_acc = 4'd0; row_acc_cnt = 4'd2;
      strobe("R8 no entries", 2'd3, 1'b1);
      set_entry(1, 1'b1, 2'd0, 4'd6);
      strobe("R8 hit keeps open", 2'd3, 1'b0);
      set_entry(1, 1'b0, 2'd0, 4'd6);
      strobe("R6 rank mismatch not hit", 2'd3, 1'b1);
      set_entry(1, 1'b1, 2'd0, 4'd6);
      pend_valid[1] = 1'b0;
      strobe("R6 invalid hit ignored", 2'd3, 1'b1);
   endtask

   task automatic t_self();
      clear_entries();
      req_rank = 1'b0; req_bank = 2'd1; req_row = 4'd2;
      max_acc = 4'd0; row_acc_cnt = 4'd1;
      set_entry(2, 1'b0, 2'd1, 4'd2);
      self_valid = 1'b1; self_idx = 2'd2;
      strobe("R9 self excluded close-adaptive", 2'd3, 1'b1);
      self_valid = 1'b0;
      strobe("R9 self flag off counts hit", 2'd3, 1'b0);
      set_entry(0, 1'b0, 2'd1, 4'd8);
      self_valid = 1'b1; self_idx = 2'd0;
      strobe("R9 self conflict excluded", 2'd1, 1'b0);
      self_idx = 2'd2;
      strobe("R9 other slot self", 2'd1, 1'b1);
   endtask

   task automatic t_hold();
      clear_entries();
      max_acc = 4'd0;
      strobe("R4 close before hold", 2'd2, 1'b1);
      policy = 2'd0;
      @(negedge clk);
      check("R1 no strobe no valid", dec_valid, 1'b0);
      check("R2 close held", dec_close, 1'b1);
      max_acc = 4'd1; row_acc_cnt = 4'd0; policy = 2'd0;
      @(negedge clk);
      check("R2 close still held", dec_close, 1'b1);
      strobe("R3 open after hold", 2'd0, 1'b0);
      policy = 2'd2;
      @(negedge clk);
      check("R2 open held", dec_close, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fixed();
      t_limit();
      t_open_adapt();
      t_close_adapt();
      t_self();
      t_hold();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule